// File: doc/BRIEF.md
# Pulse-Driven Synaptic Weight Updater

This block keeps the weight of one synapse as a 5-bit unsigned code, which gives 32 levels. It changes that code during on-chip learning. A learning request is a one-cycle strobe that carries an error direction bit and a 5-bit error magnitude. The block turns the request into a burst of single-cycle step pulses. The pulses appear on the raise line when the error is positive and on the lower line when it is negative. The number of pulses equals the magnitude. Each pulse moves the stored code by one level. At the top and bottom of the range the code saturates.

The stored code is driven out all the time as five binary-weighted select lines. Line i stands for a reference of weight 2^i, so a downstream analog summing stage can form the weight voltage. Recall reads these lines at any moment, including in the middle of a burst. No refresh cycle is ever needed. A synchronous reset reloads a parameterised starting code and drops any burst that is in progress.

Top module: `syn_weight_updater`

## Requirements
- R1: While `rst` is high at a clock edge, `weight_code` loads INIT_CODE (default 16) and `busy`, `step_up` and `step_dn` are low in the following cycle.
- R2: In every cycle, `ref_sel[i]` is high exactly when bit i of `weight_code` is high. Bit 0 stands for weight 1, bit 1 for weight 2, bit 2 for 4, bit 3 for 8 and bit 4 for 16.
- R3: A cycle with `step_up` high raises `weight_code` by one at the next edge. A cycle with `step_dn` high lowers it by one. A cycle with neither pulse leaves it unchanged.
- R4: With `err_neg` = 0 a burst uses only `step_up`, and with `err_neg` = 1 only `step_dn`. The two lines are never high in the same cycle.
- R5: An accepted request with magnitude m > 0 produces exactly m pulses.
- R6: Each pulse lasts one cycle and is followed by at least one cycle with no pulse. The first pulse occurs in the cycle right after the edge that accepted the strobe.
- R7: A raise pulse at code 31 leaves the code at 31, and a lower pulse at code 0 leaves it at 0. The pulse still counts toward the burst.
- R8: `busy` is high from the cycle after an accepted strobe through the cycle of the last pulse. A strobe that arrives while `busy` is high is ignored.
- R9: A strobe with magnitude 0 produces no pulse, keeps `busy` low and leaves the code unchanged.
- R10: A reset during a burst ends it at once. No further pulses follow, and the code returns to INIT_CODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| learn_start | input | 1 | One-cycle learning request strobe |
| err_neg | input | 1 | Error direction: 1 = negative (lower the weight) |
| err_mag | input | 5 | Error magnitude, number of steps |
| busy | output | 1 | A burst is in progress |
| step_up | output | 1 | Raise pulse |
| step_dn | output | 1 | Lower pulse |
| weight_code | output | 5 | Stored weight code |
| ref_sel | output | 5 | Binary-weighted reference selects, bit i = weight 2^i |

## Verification
Bursts of magnitude 3 and 5 in each direction confirm that the direction bit steers the pulses and that the pulse count follows the magnitude. A magnitude-31 raise from a mid-range code and a magnitude-31 lower from the top separate saturation from wraparound. A further lower at code 0 checks that a pulse taken at the limit still leaves the code in place. A second strobe sent mid-burst with the opposite direction would change the final code if it were accepted, so it shows whether strobes are ignored while busy. A zero-magnitude strobe and a reset in the middle of a burst show that nothing runs after each of them.

// File: rtl/swu_pkg.sv
package swu_pkg;

    // Pulse generator phase: fire emits one step, gap is the idle spacer.
    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_FIRE = 2'd1,
        PG_GAP  = 2'd2
    } pg_state_e;

    // One-cycle step command travelling from the generator to the register.
    typedef struct packed {
        logic up;
        logic dn;
    } step_cmd_t;

    // Steer a single fire slot onto one of the two lines.
    function automatic step_cmd_t steer_step(input logic fire, input logic negative);
        step_cmd_t c;
        c.up = fire & ~negative;
        c.dn = fire &  negative;
        return c;
    endfunction

endpackage

// File: rtl/swu_burst_gen.sv
module swu_burst_gen
    import swu_pkg::*;
#(
    parameter int MAG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             neg,
    input  logic [MAG_W-1:0] mag,
    output logic             busy,
    output step_cmd_t        cmd
);

    localparam logic [MAG_W-1:0] ONE_M  = MAG_W'(1);
    localparam logic [MAG_W-1:0] ZERO_M = '0;

    pg_state_e        st_q, st_d;
    logic [MAG_W-1:0] rem_q, rem_d;
    logic             neg_q, neg_d;

    always_comb begin
        st_d  = st_q;
        rem_d = rem_q;
        neg_d = neg_q;
        case (st_q)
            PG_IDLE: begin
                if (start && (mag != ZERO_M)) begin
                    st_d  = PG_FIRE;
                    rem_d = mag - ONE_M;
                    neg_d = neg;
                end
            end
            PG_FIRE: begin
                st_d = (rem_q == ZERO_M) ? PG_IDLE : PG_GAP;
            end
            PG_GAP: begin
                st_d  = PG_FIRE;
                rem_d = rem_q - ONE_M;
            end
            default: st_d = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PG_IDLE;
            rem_q <= ZERO_M;
            neg_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            rem_q <= rem_d;
            neg_q <= neg_d;
        end
    end

    assign busy = (st_q != PG_IDLE);
    assign cmd  = steer_step(st_q == PG_FIRE, neg_q);

endmodule

// File: rtl/swu_weight_reg.sv
module swu_weight_reg
    import swu_pkg::*;
#(
    parameter int CODE_W    = 5,
    parameter int INIT_CODE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  step_cmd_t         cmd,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] TOP_C  = '1;
    localparam logic [CODE_W-1:0] BOT_C  = '0;
    localparam logic [CODE_W-1:0] ONE_C  = CODE_W'(1);
    localparam logic [CODE_W-1:0] INIT_V = CODE_W'(INIT_CODE);

    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= INIT_V;
        end else if (cmd.up && (code_q != TOP_C)) begin
            code_q <= code_q + ONE_C;
        end else if (cmd.dn && (code_q != BOT_C)) begin
            code_q <= code_q - ONE_C;
        end
    end

    assign code = code_q;

endmodule

// File: rtl/swu_ref_drive.sv
module swu_ref_drive #(
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] sel
);

    // Each select gates the reference whose weight is 2^i.
    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
        assign sel[i] = code[i];
    end

endmodule

// File: rtl/syn_weight_updater.sv
module syn_weight_updater
    import swu_pkg::*;
#(
    parameter int CODE_W    = 5,
    parameter int MAG_W     = 5,
    parameter int INIT_CODE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              learn_start,
    input  logic              err_neg,
    input  logic [MAG_W-1:0]  err_mag,
    output logic              busy,
    output logic              step_up,
    output logic              step_dn,
    output logic [CODE_W-1:0] weight_code,
    output logic [CODE_W-1:0] ref_sel
);

    step_cmd_t step_cmd;

    swu_burst_gen #(.MAG_W(MAG_W)) u_gen (
        .clk   (clk),
        .rst   (rst),
        .start (learn_start),
        .neg   (err_neg),
        .mag   (err_mag),
        .busy  (busy),
        .cmd   (step_cmd)
    );

    swu_weight_reg #(.CODE_W(CODE_W), .INIT_CODE(INIT_CODE)) u_wreg (
        .clk  (clk),
        .rst  (rst),
        .cmd  (step_cmd),
        .code (weight_code)
    );

    swu_ref_drive #(.CODE_W(CODE_W)) u_ref (
        .code (weight_code),
        .sel  (ref_sel)
    );

    assign step_up = step_cmd.up;
    assign step_dn = step_cmd.dn;

endmodule

// File: rtl/swu_checker.sv
module swu_checker #(
    parameter int CODE_W    = 5,
    parameter int INIT_CODE = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              step_up,
    input logic              step_dn,
    input logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] TOP_C  = '1;
    localparam logic [CODE_W-1:0] BOT_C  = '0;
    localparam logic [CODE_W-1:0] ONE_C  = CODE_W'(1);
    localparam logic [CODE_W-1:0] INIT_V = CODE_W'(INIT_CODE);

    AST_RESET_LOAD: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code == INIT_V && !busy && !step_up && !step_dn)); // R1

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (step_up && code != TOP_C) |=> (code == $past(code) + ONE_C)); // R3

    AST_DN_STEP: assert property (@(posedge clk) disable iff (rst)
        (step_dn && code != BOT_C) |=> (code == $past(code) - ONE_C)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!step_up && !step_dn) |=> $stable(code)); // R3

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({step_up, step_dn})); // R4

    AST_PULSE_GAP: assert property (@(posedge clk) disable iff (rst)
        (step_up || step_dn) |=> (!step_up && !step_dn)); // R6

    AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
        (step_up && code == TOP_C) |=> (code == TOP_C)); // R7

    AST_SAT_BOT: assert property (@(posedge clk) disable iff (rst)
        (step_dn && code == BOT_C) |=> (code == BOT_C)); // R7

    AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (step_up || step_dn) |-> busy); // R8

endmodule

bind syn_weight_updater swu_checker #(
    .CODE_W    (CODE_W),
    .INIT_CODE (INIT_CODE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .step_up (step_up),
    .step_dn (step_dn),
    .code    (weight_code)
);

// File: tb/sim_syn_weight_updater.sv
`timescale 1ns/1ps
module sim_syn_weight_updater;

    localparam int INIT = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       learn_start = 1'b0;
    logic       err_neg = 1'b0;
    logic [4:0] err_mag = '0;
    logic       busy, step_up, step_dn;
    logic [4:0] weight_code, ref_sel;

    int n_cmp = 0;
    int n_bad = 0;
    int up_seen = 0;
    int dn_seen = 0;
    bit live = 1'b0;
    bit done = 1'b0;

    // behavioural model state
    int  m_phase = 0;   // 0 rest, 1 pulse slot, 2 spacer slot
    int  m_left  = 0;   // pulses still owed after the current one
    bit  m_neg   = 1'b0;
    int  m_code  = INIT;

    always #10 clk = ~clk;   // 50 MHz

    syn_weight_updater u0 (
        .clk         (clk),
        .rst         (rst),
        .learn_start (learn_start),
        .err_neg     (err_neg),
        .err_mag     (err_mag),
        .busy        (busy),
        .step_up     (step_up),
        .step_dn     (step_dn),
        .weight_code (weight_code),
        .ref_sel     (ref_sel)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // model advance at every edge, from the inputs seen before the edge
    always @(posedge clk) begin
        live <= 1'b1;
        if (rst) begin
            m_phase = 0; m_left = 0; m_code = INIT;
        end else if (m_phase == 1) begin
            if (!m_neg && m_code < 31) m_code = m_code + 1;
            if (m_neg && m_code > 0)   m_code = m_code - 1;
            m_phase = (m_left == 0) ? 0 : 2;
        end else if (m_phase == 2) begin
            m_phase = 1; m_left = m_left - 1;
        end else if (learn_start && err_mag != 0) begin
            m_phase = 1; m_left = int'(err_mag) - 1; m_neg = err_neg;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (live && !done) begin
            check("R8", "busy", int'(busy), int'(m_phase != 0));
            check("R4 R6", "step_up", int'(step_up), int'(m_phase == 1 && !m_neg));
            check("R4 R6", "step_dn", int'(step_dn), int'(m_phase == 1 && m_neg));
            check("R3", "weight_code", int'(weight_code), m_code);
            check("R2", "ref_sel", int'(ref_sel), m_code);
            if (step_up) up_seen++;
            if (step_dn) dn_seen++;
        end
    end

    task automatic burst(input bit neg, input int mag);
        up_seen = 0; dn_seen = 0;
        @(negedge clk);
        learn_start = 1'b1; err_neg = neg; err_mag = 5'(mag);
        @(negedge clk);
        learn_start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "code after reset", int'(weight_code), INIT);
        check("R1", "busy after reset", int'(busy), 0);
        // R2: bit 4 (weight 16) alone selected
        check("R2", "select for 16", int'(ref_sel), 5'b10000);

        burst(1'b0, 3);
        check("R5", "up pulses m=3", up_seen, 3);
        check("R4", "down pulses on raise", dn_seen, 0);
        check("R3", "code 16+3", int'(weight_code), 19);

        burst(1'b1, 5);
        check("R5", "down pulses m=5", dn_seen, 5);
        check("R4", "up pulses on lower", up_seen, 0);
        check("R3", "code 19-5", int'(weight_code), 14);

        // R8: second strobe mid-burst must be ignored
        up_seen = 0; dn_seen = 0;
        @(negedge clk);
        learn_start = 1'b1; err_neg = 1'b0; err_mag = 5'd4;
        @(negedge clk);
        learn_start = 1'b0;
        @(negedge clk);
        learn_start = 1'b1; err_neg = 1'b1; err_mag = 5'd9;
        @(negedge clk);
        learn_start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        check("R8", "ignored strobe down pulses", dn_seen, 0);
        check("R8", "code 14+4", int'(weight_code), 18);

        // R9: zero magnitude
        up_seen = 0; dn_seen = 0;
        @(negedge clk);
        learn_start = 1'b1; err_neg = 1'b0; err_mag = 5'd0;
        @(negedge clk);
        learn_start = 1'b0;
        check("R9", "busy after zero strobe", int'(busy), 0);
        repeat (3) @(negedge clk);
        check("R9", "pulses for zero", up_seen + dn_seen, 0);
        check("R9", "code unchanged", int'(weight_code), 18);

        // R7: saturation at top
        burst(1'b0, 31);
        check("R5", "up pulses m=31", up_seen, 31);
        check("R7", "code at top", int'(weight_code), 31);

        // R7: saturation at bottom
        burst(1'b1, 31);
        check("R7", "code at bottom", int'(weight_code), 0);
        burst(1'b1, 1);
        check("R7", "pulse at zero consumed", dn_seen, 1);
        check("R7", "code stays 0", int'(weight_code), 0);

        // R10: reset mid-burst
        up_seen = 0;
        @(negedge clk);
        learn_start = 1'b1; err_neg = 1'b0; err_mag = 5'd10;
        @(negedge clk);
        learn_start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10", "busy after abort", int'(busy), 0);
        check("R10", "code after abort", int'(weight_code), INIT);
        up_seen = 0;
        repeat (6) @(negedge clk);
        check("R10", "pulses after abort", up_seen, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule